// File: doc/BRIEF.md
# Card-Side DMA Request Channel

This block sits on an expansion card and runs the peripheral half of the single-channel DMA handshake on a 16-bit expansion bus. A local data source signals, asynchronously, that it wants service. The block synchronizes that request and raises a DMA request line. It keeps the line high until the host controller answers with its active-low acknowledge. During an acknowledged cycle the bus drives no address that the card could decode, so the I/O read and I/O write strobes count only while the acknowledge is low. Under those strobes the block either places one word from the local source on the data bus or captures one word for the local sink.

The channel number is a parameter and sets the word width. Channels 0 to 3 move bytes on the low lane. Channels 5 to 7 move 16-bit words on both lanes. Channel 4 is reserved for the host board and is not a legal value. The terminal-count pulse that arrives during an acknowledged strobe ends the block. It sets a sticky completion flag, which holds the request low until a local clear. In cascade mode the block moves no data. It pulls the bus-master line low after the acknowledge so that the card's own master logic can take over the bus. All bus inputs are sampled on the block clock.

Top module: `isa_dreq_channel`

## Requirements
- R1: After reset `dreq` is low. A rise on `src_req` shows on `dreq` after the third rising clock edge: two synchronizer stages, then the request register.
- R2: Once `dreq` is high it stays high at every edge where `dack_n` is sampled high, even if `src_req` has been withdrawn. The only exception is completion (R11).
- R3: At an edge where `dack_n` is sampled low, `dreq` takes the synchronized request. It falls if no data is pending and stays high if the request is still present.
- R4: Channels 0 to 3 use only byte lane 0 (bits 7:0): `bus_oe` is `2'b01` when driving, and bits 15:8 of `bus_dout` and `snk_data` stay 0. Channels 5 to 7 use both lanes, and `bus_oe` is `2'b11` when driving.
- R5: With `xfer_dir`=1 (card to memory), `cascade_en`=0, `dack_n`=0 and `ior_n`=0, `bus_oe` shows the active lanes and `bus_dout` equals `src_data` in the same cycle, with no clock. In every other input combination `bus_oe` is 0.
- R6: With `xfer_dir`=0 (memory to card), `cascade_en`=0, `dack_n`=0 and `iow_n`=0, `snk_data` loads `bus_din` at every such edge, so the last word sampled under the strobe remains.
- R7: `beat` is a one-cycle pulse. It is high after the first edge at which a previously sampled, qualified strobe is seen released.
- R8: A read or write strobe while `dack_n` is high drives no lane, captures nothing and produces no `beat`.
- R9: `done` is set at an edge where `tc` is high, `dack_n` is low and a qualified strobe is active. Once set, `done` stays set. A `tc` pulse without an acknowledged strobe is ignored.
- R10: `done_clr` clears `done` at the next edge. If a set condition and a clear fall on the same edge, the set wins.
- R11: `dreq` falls at the edge where `done` is set and stays low while `done` is high, whatever the request. After the clear it may rise again.
- R12: With `cascade_en`=1, `master_n` goes low after the first edge that samples `dack_n` low and goes high after the first edge that samples it high. In cascade mode no lane is driven, no `beat` occurs and `tc` does not set `done`.
- R13: Reset (synchronous, active high) gives `dreq`=0, `master_n`=1, `done`=0, `beat`=0 and `snk_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 1 | Asynchronous service request from the local source |
| xfer_dir | input | 1 | 1 = card to memory (I/O read), 0 = memory to card (I/O write) |
| cascade_en | input | 1 | Bus-master takeover instead of data moves |
| dack_n | input | 1 | DMA acknowledge, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| tc | input | 1 | Terminal-count pulse, active high |
| done_clr | input | 1 | Clears the completion flag |
| src_data | input | 16 | Word offered by the local source |
| bus_din | input | 16 | Data bus as seen by the card |
| dreq | output | 1 | DMA request, active high |
| master_n | output | 1 | Bus-master takeover, active low |
| done | output | 1 | Sticky block-complete flag |
| beat | output | 1 | One word moved |
| bus_dout | output | 16 | Data the card drives onto the bus |
| bus_oe | output | 2 | Per-byte-lane drive enables |
| snk_data | output | 16 | Word captured for the local sink |

## Verification
The bench withdraws the request before the acknowledge arrives. A design that drops the request early loses the transfer, and the bench sees `dreq` fall while `dack_n` is still high. It sends strobes and `tc` pulses without the acknowledge, and in cascade mode. A decoder that ignores the acknowledge would drive the bus or end the block at the wrong time. It makes a set and a clear of `done` fall on the same edge, where a clear-first design would drop the end-of-block event. It holds a request pending through completion, which a design would wrongly re-request.

// File: rtl/isa_dreq_pkg.sv
package isa_dreq_pkg;

    localparam int unsigned LANE_BITS = 8;
    localparam int unsigned MAX_LANES = 2;
    localparam int unsigned BUS_BITS  = LANE_BITS * MAX_LANES;

    typedef enum logic {
        DIR_FROM_MEM = 1'b0,
        DIR_TO_MEM   = 1'b1
    } xfer_dir_e;

    // Bus inputs decoded to active-high form
    typedef struct packed {
        logic ack;
        logic rd;
        logic wr;
        logic tc;
    } bus_view_t;

    // Registered control state leaving the controller
    typedef struct packed {
        logic drq;
        logic master;
        logic done;
    } ctrl_state_t;

    // Low channels move bytes, high channels move words
    function automatic int unsigned lanes_for_channel(input int unsigned ch);
        return (ch >= 5) ? 2 : 1;
    endfunction

endpackage

// File: rtl/isa_dreq_sync.sv
module isa_dreq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/isa_dreq_ctrl.sv
module isa_dreq_ctrl
    import isa_dreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_s,
    input  logic        cascade_en,
    input  logic        ack,
    input  logic        tc,
    input  logic        strobe_act,
    input  logic        done_clr,
    output ctrl_state_t st
);
    logic drq_q, master_q, done_q;
    logic done_set;

    // End of block only counts under an acknowledged data strobe
    assign done_set = tc && ack && strobe_act && !cascade_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            drq_q    <= 1'b0;
            master_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q   <= done_set || (done_q && !done_clr);
            master_q <= cascade_en && ack;
            if (done_q || done_set)
                drq_q <= 1'b0;
            else
                drq_q <= (drq_q && !ack) || req_s;
        end
    end

    assign st.drq    = drq_q;
    assign st.master = master_q;
    assign st.done   = done_q;

    assert_drq_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (drq_q && !ack && !done_q) |=> drq_q);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (done_q && !done_clr) |=> done_q);

    assert_drq_off_when_done_R11: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !drq_q);

    assert_master_needs_cascade_R12: assert property (@(posedge clk) disable iff (rst)
        master_q |-> $past(cascade_en && ack));

endmodule

// File: rtl/isa_dreq_datapath.sv
module isa_dreq_datapath
    import isa_dreq_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ack,
    input  logic                 rd,
    input  logic                 wr,
    input  xfer_dir_e            dir,
    input  logic                 cascade_en,
    input  logic [BUS_BITS-1:0]  src_data,
    input  logic [BUS_BITS-1:0]  bus_din,
    output logic [BUS_BITS-1:0]  bus_dout,
    output logic [MAX_LANES-1:0] bus_oe,
    output logic [BUS_BITS-1:0]  snk_data,
    output logic                 beat,
    output logic                 strobe_act
);
    logic rd_act, wr_act;
    logic act_q, beat_q;

    // The acknowledge replaces the address decode
    assign rd_act     = ack && rd && (dir == DIR_TO_MEM)   && !cascade_en;
    assign wr_act     = ack && wr && (dir == DIR_FROM_MEM) && !cascade_en;
    assign strobe_act = rd_act || wr_act;

    generate
        for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
            if (g < LANES) begin : g_on
                logic [LANE_BITS-1:0] cap_q;
                always_ff @(posedge clk) begin
                    if (rst)         cap_q <= '0;
                    else if (wr_act) cap_q <= bus_din[g*LANE_BITS +: LANE_BITS];
                end
                assign snk_data[g*LANE_BITS +: LANE_BITS] = cap_q;
                assign bus_dout[g*LANE_BITS +: LANE_BITS] = src_data[g*LANE_BITS +: LANE_BITS];
                assign bus_oe[g] = rd_act;
            end else begin : g_off
                assign snk_data[g*LANE_BITS +: LANE_BITS] = '0;
                assign bus_dout[g*LANE_BITS +: LANE_BITS] = '0;
                assign bus_oe[g] = 1'b0;
            end
        end
    endgenerate

    // A word counts as moved when its strobe is released
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            beat_q <= 1'b0;
        end else begin
            act_q  <= strobe_act;
            beat_q <= act_q && !strobe_act;
        end
    end

    assign beat = beat_q;

    assert_oe_needs_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (|bus_oe) |-> ack);

    assert_beat_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
        beat_q |-> $past(ack, 2));

endmodule

// File: rtl/isa_dreq_channel.sv
module isa_dreq_channel
    import isa_dreq_pkg::*;
#(
    parameter int unsigned CHANNEL     = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        src_req,
    input  logic        xfer_dir,
    input  logic        cascade_en,
    input  logic        dack_n,
    input  logic        ior_n,
    input  logic        iow_n,
    input  logic        tc,
    input  logic        done_clr,
    input  logic [15:0] src_data,
    input  logic [15:0] bus_din,
    output logic        dreq,
    output logic        master_n,
    output logic        done,
    output logic        beat,
    output logic [15:0] bus_dout,
    output logic [1:0]  bus_oe,
    output logic [15:0] snk_data
);
    localparam int unsigned LANES = lanes_for_channel(CHANNEL);

    bus_view_t   view;
    ctrl_state_t st;
    logic        req_s;
    logic        strobe_act;

    assign view.ack = !dack_n;
    assign view.rd  = !ior_n;
    assign view.wr  = !iow_n;
    assign view.tc  = tc;

    isa_dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_req),
        .q   (req_s)
    );

    isa_dreq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_s      (req_s),
        .cascade_en (cascade_en),
        .ack        (view.ack),
        .tc         (view.tc),
        .strobe_act (strobe_act),
        .done_clr   (done_clr),
        .st         (st)
    );

    isa_dreq_datapath #(.LANES(LANES)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .ack        (view.ack),
        .rd         (view.rd),
        .wr         (view.wr),
        .dir        (xfer_dir_e'(xfer_dir)),
        .cascade_en (cascade_en),
        .src_data   (src_data),
        .bus_din    (bus_din),
        .bus_dout   (bus_dout),
        .bus_oe     (bus_oe),
        .snk_data   (snk_data),
        .beat       (beat),
        .strobe_act (strobe_act)
    );

    assign dreq     = st.drq;
    assign master_n = !st.master;
    assign done     = st.done;

endmodule

// File: tb/sim_isa_dreq_channel.sv
module sim_isa_dreq_channel;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_req = 0, xfer_dir = 0, cascade_en = 0;
    logic dack_n = 1, ior_n = 1, iow_n = 1, tc = 0, done_clr = 0;
    logic [15:0] src_data = '0, bus_din = '0;

    logic dreq, master_n, done, beat;
    logic [15:0] bus_dout, snk_data;
    logic [1:0] bus_oe;
    logic dreq_b, master_n_b, done_b, beat_b;
    logic [15:0] bus_dout_b, snk_data_b;
    logic [1:0] bus_oe_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    isa_dreq_channel #(.CHANNEL(5)) u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .xfer_dir(xfer_dir),
        .cascade_en(cascade_en), .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
        .tc(tc), .done_clr(done_clr), .src_data(src_data), .bus_din(bus_din),
        .dreq(dreq), .master_n(master_n), .done(done), .beat(beat),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .snk_data(snk_data));

    isa_dreq_channel #(.CHANNEL(2)) u1 (
        .clk(clk), .rst(rst), .src_req(src_req), .xfer_dir(xfer_dir),
        .cascade_en(cascade_en), .dack_n(dack_n), .ior_n(ior_n), .iow_n(iow_n),
        .tc(tc), .done_clr(done_clr), .src_data(src_data), .bus_din(bus_din),
        .dreq(dreq_b), .master_n(master_n_b), .done(done_b), .beat(beat_b),
        .bus_dout(bus_dout_b), .bus_oe(bus_oe_b), .snk_data(snk_data_b));

    // [6] dack_n [5] ior_n [4] iow_n [3] xfer_dir [2] cascade_en [1:0] expected bus_oe of u0
    localparam logic [6:0] VEC [6] = '{
        7'b0_0_1_1_0_11,
        7'b1_0_1_1_0_00,
        7'b0_1_1_1_0_00,
        7'b0_0_1_0_0_00,
        7'b0_0_1_1_1_00,
        7'b0_1_0_0_0_00
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_bus;
        dack_n = 1; ior_n = 1; iow_n = 1; tc = 0; done_clr = 0;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick; tick; tick;
        rst = 0;
        tick;
        // R13 reset state
        chk(dreq, 0, "R13 dreq");
        chk(master_n, 1, "R13 master_n");
        chk(done, 0, "R13 done");
        chk(beat, 0, "R13 beat");
        chk(snk_data, 16'h0000, "R13 snk_data");

        // Table walk: lane enables, combinational (R5 R8 R12 R4)
        src_data = 16'h5AC3;
        for (int i = 0; i < 6; i++) begin
            {dack_n, ior_n, iow_n, xfer_dir, cascade_en} = VEC[i][6:2];
            #1;
            chk(bus_oe, VEC[i][1:0], "R5 table bus_oe");
            chk(bus_oe_b, {1'b0, VEC[i][0]}, "R4 table bus_oe 8-bit");
            if (VEC[i][1:0] == 2'b11) begin
                chk(bus_dout, 16'h5AC3, "R5 table bus_dout");
                chk(bus_dout_b, 16'h00C3, "R4 table bus_dout 8-bit");
            end
        end
        idle_bus(); cascade_en = 0; xfer_dir = 0;
        rst = 1; tick; tick; rst = 0; tick;

        // R1 synchronized rise
        src_req = 1;
        tick; tick;
        chk(dreq, 0, "R1 dreq before third edge");
        tick;
        chk(dreq, 1, "R1 dreq at third edge");

        // R2 held after withdrawal
        src_req = 0;
        tick; tick; tick; tick;
        chk(dreq, 1, "R2 dreq held without dack");

        // R3 fall when nothing pending
        dack_n = 0;
        tick;
        chk(dreq, 0, "R3 dreq falls on dack");
        chk(master_n, 1, "R12 no master without cascade");
        src_req = 1;
        tick; tick; tick;
        chk(dreq, 1, "R3 dreq rises under dack when pending");
        tick;
        chk(dreq, 1, "R3 dreq stays with pending data");

        // R5 R7 card to memory
        xfer_dir = 1; src_data = 16'hC35A; ior_n = 0;
        #1;
        chk(bus_dout, 16'hC35A, "R5 bus_dout");
        chk(bus_oe, 2'b11, "R5 bus_oe");
        tick;
        ior_n = 1;
        tick;
        chk(beat, 1, "R7 beat after read strobe");
        tick;
        chk(beat, 0, "R7 beat one cycle");

        // R6 R4 memory to card
        xfer_dir = 0; bus_din = 16'h9E17; iow_n = 0;
        tick;
        chk(snk_data, 16'h9E17, "R6 capture");
        chk(snk_data_b, 16'h0017, "R4 capture 8-bit");
        bus_din = 16'h4411;
        tick;
        chk(snk_data, 16'h4411, "R6 last word wins");
        iow_n = 1;
        tick;
        chk(beat, 1, "R7 beat after write strobe");
        bus_din = 16'hFFFF;
        tick;
        chk(snk_data, 16'h4411, "R6 no capture without strobe");

        // R8 strobe without dack
        dack_n = 1; iow_n = 0; bus_din = 16'h0BAD;
        tick; tick;
        iow_n = 1;
        tick;
        chk(snk_data, 16'h4411, "R8 no capture without dack");
        chk(beat, 0, "R8 no beat without dack");

        // R9 tc ignored without acknowledged strobe
        tc = 1;
        tick;
        chk(done, 0, "R9 tc without dack ignored");
        dack_n = 0;
        tick;
        chk(done, 0, "R9 tc without strobe ignored");
        tc = 0;

        // R9 R11 completion
        xfer_dir = 1; ior_n = 0; tc = 1;
        tick;
        chk(done, 1, "R9 done set");
        chk(dreq, 0, "R11 dreq drops with done");
        idle_bus();
        tick; tick; tick;
        chk(done, 1, "R9 done sticky");
        chk(dreq, 0, "R11 dreq low while done");

        // R10 clear, then R11 recovery
        done_clr = 1;
        tick;
        chk(done, 0, "R10 done cleared");
        done_clr = 0;
        tick;
        chk(dreq, 1, "R11 dreq returns after clear");

        // R10 set wins over clear
        dack_n = 0; ior_n = 0; tc = 1; done_clr = 1;
        tick;
        chk(done, 1, "R10 set wins over clear");
        idle_bus(); done_clr = 1;
        tick;
        chk(done, 0, "R10 clear after set");
        done_clr = 0;

        // R12 cascade
        cascade_en = 1;
        tick;
        chk(dreq, 1, "R12 request in cascade");
        dack_n = 0; ior_n = 0; xfer_dir = 1;
        #1;
        chk(bus_oe, 2'b00, "R12 no drive in cascade");
        tick;
        chk(master_n, 0, "R12 master low after dack");
        tc = 1;
        tick;
        chk(done, 0, "R12 tc ignored in cascade");
        tc = 0; ior_n = 1;
        tick;
        chk(beat, 0, "R12 no beat in cascade");
        dack_n = 1;
        tick;
        chk(master_n, 1, "R12 master released");
        cascade_en = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule